// File: doc/BRIEF.md
# Linear CCD Clock Timing Generator

This block derives every digital drive clock for a three-color linear CCD with an odd and an even output per color from a single master clock. It produces the transfer-gate pulse, the complementary two-phase shift clocks, the last-stage shift clock, the reset-gate pulse and the reset-level clamp pulse. Every interval is a count of master-clock cycles.

A line begins with a transfer window. The shift clocks are frozen in the phase that receives charge. A guard interval separates that phase from the transfer-gate rise, and a second guard follows the transfer-gate fall. Readout then shifts a fixed number of register elements, one per pixel period, and the shift clocks keep running until the programmed line period ends. The reset-gate and clamp pulses repeat in every pixel period, including the transfer window.

Capture logic gets two signals: a one-cycle line-start strobe and an element index with a valid flag. The transfer-gate width and the line period (the storage time) are taken from input ports, and both are latched once per line.

Top module: `lccd_clkgen`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, the outputs are idle: transfer gate 0, shift clock 1 = 1, shift clock 2 = 0, last-stage clock = 1, reset gate 0, clamp 0, line start 0, element valid 0, element index 0.
- R2: The line-start strobe is high for exactly one cycle. It first appears in the second cycle after reset is released, and the cycle in which it is high is line time 0.
- R3: The transfer gate is high for exactly T cycles, from line time GUARD to line time GUARD+T-1. T is the requested width clamped to [TG_MIN, TG_MAX].
- R4: Shift clock 1 is held at 1 from line time 0 until pixel R0 of the line, where R0 = ceil((2*GUARD+T)/PIX). Its first falling edge therefore comes at least GUARD cycles after the transfer gate falls.
- R5: Shift clock 2 is always the complement of shift clock 1, and the last-stage clock always equals shift clock 1.
- R6: Outside the hold, shift clock 1 is 1 in the first PIX/2 cycles of each PIX-cycle pixel period (phase 0 at line time 0) and 0 in the rest.
- R7: The reset gate is high at pixel phases RB_POS to RB_POS+RB_LEN-1 in every pixel period of the line, including the transfer window.
- R8: The clamp pulse is high for CL_LEN cycles starting at phase RB_POS+RB_LEN-CL_OVL. It may overlap the reset gate by CL_OVL cycles, and it rises only while the reset gate is high or in the cycle the reset gate falls.
- R9: The element valid flag is high for exactly NE pixel periods, starting at pixel R0. The index counts 0 to NE-1, one step per pixel period, and reads 0 whenever valid is low.
- R10: The line period is max(requested pixels, R0+NE) pixel periods. The width and period inputs are sampled only at a line start, so a change in the middle of a line takes effect at the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_len_i | input | TG_W | Requested transfer-gate width in cycles |
| line_pix_i | input | LP_W | Requested line period in pixel periods |
| xfer_gate_o | output | 1 | Transfer-gate pulse |
| sh1_o | output | 1 | Shift clock phase 1 |
| sh2_o | output | 1 | Shift clock phase 2 |
| sh_last_o | output | 1 | Last-stage shift clock |
| rst_gate_o | output | 1 | Reset-gate pulse |
| clamp_o | output | 1 | Reset-level clamp pulse |
| line_start_o | output | 1 | One-cycle strobe at line time 0 |
| elem_vld_o | output | 1 | Readout element valid |
| elem_idx_o | output | IDX_W | Readout element index |

## Verification
A slip in the pixel phase counter moves the reset-gate and clamp pulses and the shift-clock edges within one pixel period, so it shows at the ports in under PIX cycles. A wrong latched width or readout start shows in the transfer-gate edges or the element-valid rise during the first line after the fault. A wrong line-period count or a mid-line sample of the inputs is only seen at the next line-start strobe, which can be a full line later. For that reason the reference model compares every output on every cycle across several lines that use different width and period settings.

// File: rtl/lccd_pkg.sv
package lccd_pkg;

  // Clamp a requested transfer-gate width into the legal window.
  function automatic int unsigned tg_eff(int unsigned req, int unsigned lo, int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // First pixel index of readout: the smallest pixel boundary at or after the end of the window.
  function automatic int unsigned first_rd(int unsigned tg, int unsigned guard, int unsigned pix);
    return (2 * guard + tg + pix - 1) / pix;
  endfunction

  // Line period in pixel periods, never shorter than the window plus the readout.
  function automatic int unsigned line_eff(int unsigned req, int unsigned r0, int unsigned ne);
    if (req < r0 + ne) return r0 + ne;
    return req;
  endfunction

endpackage

// File: rtl/lccd_pix_phase.sv
module lccd_pix_phase #(
  parameter int unsigned PIX = 14,
  parameter int unsigned P_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  output logic [P_W-1:0] phase,
  output logic           phase_last
);

  assign phase_last = (phase == P_W'(PIX - 1));

  always_ff @(posedge clk) begin
    if (rst || restart)  phase <= '0;
    else if (phase_last) phase <= '0;
    else                 phase <= phase + P_W'(1);
  end

endmodule

// File: rtl/lccd_line_seq.sv
module lccd_line_seq
  import lccd_pkg::*;
#(
  parameter int unsigned PIX    = 14,
  parameter int unsigned GUARD  = 190,
  parameter int unsigned TG_MIN = 1000,
  parameter int unsigned TG_MAX = 2000,
  parameter int unsigned NE     = 5138,
  parameter int unsigned TG_W   = 11,
  parameter int unsigned LP_W   = 16,
  parameter int unsigned WC_W   = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TG_W-1:0] tg_req,
  input  logic [LP_W-1:0] lp_req,
  input  logic            p_last,
  output logic            armed,
  output logic            restart,
  output logic [WC_W-1:0] wcnt,
  output logic [LP_W-1:0] pidx,
  output logic [TG_W-1:0] tg_l,
  output logic [LP_W-1:0] r0_l
);

  localparam int unsigned WC_MAX = 2 * GUARD + TG_MAX;

  logic [LP_W-1:0] lp_l;
  int unsigned     tg_n, r0_n, lp_n;

  always_comb begin
    tg_n = tg_eff(32'(tg_req), TG_MIN, TG_MAX);
    r0_n = first_rd(tg_n, GUARD, PIX);
    lp_n = line_eff(32'(lp_req), r0_n, NE);
  end

  // A new line begins after reset release and after the last cycle of a line.
  assign restart = !armed || (p_last && (pidx == lp_l - LP_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      wcnt  <= '0;
      pidx  <= '0;
      tg_l  <= TG_W'(TG_MIN);
      r0_l  <= LP_W'(first_rd(TG_MIN, GUARD, PIX));
      lp_l  <= LP_W'(first_rd(TG_MIN, GUARD, PIX) + NE);
    end else if (restart) begin
      armed <= 1'b1;
      wcnt  <= '0;
      pidx  <= '0;
      tg_l  <= TG_W'(tg_n);
      r0_l  <= LP_W'(r0_n);
      lp_l  <= LP_W'(lp_n);
    end else begin
      if (wcnt != WC_W'(WC_MAX)) wcnt <= wcnt + WC_W'(1);
      if (p_last)                pidx <= pidx + LP_W'(1);
    end
  end

endmodule

// File: rtl/lccd_clk_drive.sv
module lccd_clk_drive #(
  parameter int unsigned PIX    = 14,
  parameter int unsigned GUARD  = 190,
  parameter int unsigned NE     = 5138,
  parameter int unsigned RB_POS = 1,
  parameter int unsigned RB_LEN = 3,
  parameter int unsigned CL_LEN = 3,
  parameter int unsigned CL_OVL = 0,
  parameter int unsigned P_W    = 4,
  parameter int unsigned TG_W   = 11,
  parameter int unsigned LP_W   = 16,
  parameter int unsigned WC_W   = 12,
  parameter int unsigned IDX_W  = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic [P_W-1:0]   phase,
  input  logic [WC_W-1:0]  wcnt,
  input  logic [LP_W-1:0]  pidx,
  input  logic [TG_W-1:0]  tg_l,
  input  logic [LP_W-1:0]  r0_l,
  output logic             shift_hold,
  output logic             xfer_gate_o,
  output logic             sh1_o,
  output logic             sh2_o,
  output logic             sh_last_o,
  output logic             rst_gate_o,
  output logic             clamp_o,
  output logic             line_start_o,
  output logic             elem_vld_o,
  output logic [IDX_W-1:0] elem_idx_o
);

  localparam int unsigned CL_POS = RB_POS + RB_LEN - CL_OVL;

  int unsigned pi, wi, xi, ri, ti, rdi;
  logic        hold, in_rd, tg_d, sh_d, rg_d, cl_d, ls_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    pi    = 32'(phase);
    wi    = 32'(wcnt);
    xi    = 32'(pidx);
    ri    = 32'(r0_l);
    ti    = 32'(tg_l);
    hold  = xi < ri;
    rdi   = hold ? 0 : xi - ri;
    in_rd = armed && !hold && (rdi < NE);
    tg_d  = armed && (wi >= GUARD) && (wi < GUARD + ti);
    sh_d  = !armed || hold || (pi < PIX / 2);
    rg_d  = armed && (pi >= RB_POS) && (pi < RB_POS + RB_LEN);
    cl_d  = armed && (pi >= CL_POS) && (pi < CL_POS + CL_LEN);
    ls_d  = armed && (wi == 0);
    idx_d = in_rd ? IDX_W'(rdi) : '0;
  end

  assign shift_hold = !armed || hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_gate_o  <= 1'b0;
      sh1_o        <= 1'b1;
      sh2_o        <= 1'b0;
      sh_last_o    <= 1'b1;
      rst_gate_o   <= 1'b0;
      clamp_o      <= 1'b0;
      line_start_o <= 1'b0;
      elem_vld_o   <= 1'b0;
      elem_idx_o   <= '0;
    end else begin
      xfer_gate_o  <= tg_d;
      sh1_o        <= sh_d;
      sh2_o        <= !sh_d;
      sh_last_o    <= sh_d;
      rst_gate_o   <= rg_d;
      clamp_o      <= cl_d;
      line_start_o <= ls_d;
      elem_vld_o   <= in_rd;
      elem_idx_o   <= idx_d;
    end
  end

endmodule

// File: rtl/lccd_clkgen.sv
module lccd_clkgen #(
  parameter int unsigned PIX    = 14,
  parameter int unsigned GUARD  = 190,
  parameter int unsigned TG_MIN = 1000,
  parameter int unsigned TG_MAX = 2000,
  parameter int unsigned NE     = 5138,
  parameter int unsigned RB_POS = 1,
  parameter int unsigned RB_LEN = 3,
  parameter int unsigned CL_LEN = 3,
  parameter int unsigned CL_OVL = 0,
  parameter int unsigned LP_W   = 16,
  localparam int unsigned TG_W  = $clog2(TG_MAX + 1),
  localparam int unsigned IDX_W = $clog2(NE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TG_W-1:0]  xfer_len_i,
  input  logic [LP_W-1:0]  line_pix_i,
  output logic             xfer_gate_o,
  output logic             sh1_o,
  output logic             sh2_o,
  output logic             sh_last_o,
  output logic             rst_gate_o,
  output logic             clamp_o,
  output logic             line_start_o,
  output logic             elem_vld_o,
  output logic [IDX_W-1:0] elem_idx_o
);

  localparam int unsigned P_W  = $clog2(PIX);
  localparam int unsigned WC_W = $clog2(2 * GUARD + TG_MAX + 1);

  // Named internal events, visible to the bound checker.
  logic            armed;
  logic            restart;
  logic            phase_last;
  logic            shift_hold;
  logic [P_W-1:0]  phase;
  logic [WC_W-1:0] wcnt;
  logic [LP_W-1:0] pidx;
  logic [TG_W-1:0] tg_l;
  logic [LP_W-1:0] r0_l;

  lccd_pix_phase #(.PIX(PIX), .P_W(P_W)) u_phase (
    .clk(clk), .rst(rst), .restart(restart),
    .phase(phase), .phase_last(phase_last)
  );

  lccd_line_seq #(
    .PIX(PIX), .GUARD(GUARD), .TG_MIN(TG_MIN), .TG_MAX(TG_MAX), .NE(NE),
    .TG_W(TG_W), .LP_W(LP_W), .WC_W(WC_W)
  ) u_seq (
    .clk(clk), .rst(rst), .tg_req(xfer_len_i), .lp_req(line_pix_i),
    .p_last(phase_last), .armed(armed), .restart(restart), .wcnt(wcnt),
    .pidx(pidx), .tg_l(tg_l), .r0_l(r0_l)
  );

  lccd_clk_drive #(
    .PIX(PIX), .GUARD(GUARD), .NE(NE), .RB_POS(RB_POS), .RB_LEN(RB_LEN),
    .CL_LEN(CL_LEN), .CL_OVL(CL_OVL), .P_W(P_W), .TG_W(TG_W), .LP_W(LP_W),
    .WC_W(WC_W), .IDX_W(IDX_W)
  ) u_drive (
    .clk(clk), .rst(rst), .armed(armed), .phase(phase), .wcnt(wcnt),
    .pidx(pidx), .tg_l(tg_l), .r0_l(r0_l), .shift_hold(shift_hold),
    .xfer_gate_o(xfer_gate_o), .sh1_o(sh1_o), .sh2_o(sh2_o),
    .sh_last_o(sh_last_o), .rst_gate_o(rst_gate_o), .clamp_o(clamp_o),
    .line_start_o(line_start_o), .elem_vld_o(elem_vld_o),
    .elem_idx_o(elem_idx_o)
  );

endmodule

// File: rtl/lccd_clkgen_chk.sv
module lccd_clkgen_chk #(
  parameter int unsigned GUARD  = 190,
  parameter int unsigned TG_MIN = 1000,
  parameter int unsigned TG_MAX = 2000,
  parameter int unsigned IDX_W  = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_hold,
  input logic             xfer_gate_o,
  input logic             sh1_o,
  input logic             sh2_o,
  input logic             sh_last_o,
  input logic             rst_gate_o,
  input logic             clamp_o,
  input logic             line_start_o,
  input logic             elem_vld_o,
  input logic [IDX_W-1:0] elem_idx_o
);

  localparam int unsigned RUN_W = $clog2(TG_MAX + 2);
  localparam int unsigned GD_W  = $clog2(GUARD + 1);

  logic [RUN_W-1:0] tg_run;
  logic [GD_W-1:0]  since_tg;

  always_ff @(posedge clk) begin
    if (rst) begin
      tg_run   <= '0;
      since_tg <= GD_W'(GUARD);
    end else begin
      if (!xfer_gate_o)                     tg_run <= '0;
      else if (tg_run != RUN_W'(TG_MAX + 1)) tg_run <= tg_run + RUN_W'(1);
      if (xfer_gate_o)                      since_tg <= '0;
      else if (since_tg != GD_W'(GUARD))    since_tg <= since_tg + GD_W'(1);
    end
  end

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    line_start_o |=> !line_start_o);

  a_r3_tg_width: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_gate_o) |-> (tg_run >= RUN_W'(TG_MIN)) && (tg_run <= RUN_W'(TG_MAX)));

  a_r4_held_in_tg: assert property (@(posedge clk) disable iff (rst)
    xfer_gate_o |-> sh1_o);

  a_r4_hold_drives_out: assert property (@(posedge clk) disable iff (rst)
    shift_hold |=> sh1_o);

  a_r4_guard_after_tg: assert property (@(posedge clk) disable iff (rst)
    $fell(sh1_o) |-> (since_tg >= GD_W'(GUARD)));

  a_r5_complement: assert property (@(posedge clk) disable iff (rst)
    sh2_o == !sh1_o);

  a_r5_last_follows: assert property (@(posedge clk) disable iff (rst)
    sh_last_o == sh1_o);

  a_r8_clamp_not_late: assert property (@(posedge clk) disable iff (rst)
    $rose(clamp_o) |-> (rst_gate_o || $fell(rst_gate_o)));

  a_r9_idx_from_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(elem_vld_o) |-> (elem_idx_o == '0));

  a_r9_idx_steps: assert property (@(posedge clk) disable iff (rst)
    (elem_vld_o && $past(elem_vld_o)) |->
      ((elem_idx_o == $past(elem_idx_o)) || (elem_idx_o == $past(elem_idx_o) + IDX_W'(1))));

endmodule

bind lccd_clkgen lccd_clkgen_chk #(
  .GUARD(GUARD), .TG_MIN(TG_MIN), .TG_MAX(TG_MAX), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .shift_hold(shift_hold), .xfer_gate_o(xfer_gate_o),
  .sh1_o(sh1_o), .sh2_o(sh2_o), .sh_last_o(sh_last_o),
  .rst_gate_o(rst_gate_o), .clamp_o(clamp_o), .line_start_o(line_start_o),
  .elem_vld_o(elem_vld_o), .elem_idx_o(elem_idx_o)
);

// File: tb/lccd_clkgen_test.sv
`timescale 1ns/1ps
module lccd_clkgen_test;

  localparam int PIX = 8, G = 4, TGMIN = 6, TGMAX = 12, NE = 10;
  localparam int RBP = 1, RBL = 2, CLL = 2, CLO = 1, LPW = 8;
  localparam int TGW = $clog2(TGMAX + 1);
  localparam int IDXW = $clog2(NE);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TGW-1:0] xfer_len = '0;
  logic [LPW-1:0] line_pix = '0;
  logic xfer_gate, sh1, sh2, sh_last, rst_gate, clamp, line_start, elem_vld;
  logic [IDXW-1:0] elem_idx;

  always #2.5 clk = ~clk;

  lccd_clkgen #(
    .PIX(PIX), .GUARD(G), .TG_MIN(TGMIN), .TG_MAX(TGMAX), .NE(NE),
    .RB_POS(RBP), .RB_LEN(RBL), .CL_LEN(CLL), .CL_OVL(CLO), .LP_W(LPW)
  ) uut (
    .clk(clk), .rst(rst), .xfer_len_i(xfer_len), .line_pix_i(line_pix),
    .xfer_gate_o(xfer_gate), .sh1_o(sh1), .sh2_o(sh2), .sh_last_o(sh_last),
    .rst_gate_o(rst_gate), .clamp_o(clamp), .line_start_o(line_start),
    .elem_vld_o(elem_vld), .elem_idx_o(elem_idx)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  // Reference model state: edges since release, line time, latched settings.
  int n = 0, lt = 0, m_t = TGMIN, m_lp = 1, m_r0 = 0;
  int prev_tg = 0, prev_lp = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic new_line();
    m_t  = (prev_tg < TGMIN) ? TGMIN : (prev_tg > TGMAX) ? TGMAX : prev_tg;
    m_r0 = 0;
    while (m_r0 * PIX < 2 * G + m_t) m_r0++;
    m_lp = (prev_lp < m_r0 + NE) ? m_r0 + NE : prev_lp;
    lt   = 0;
  endtask

  task automatic step();
    bit r;
    int cur_tg, cur_lp, p, pi, e_tg, e_sh, e_rg, e_cl, e_ls, e_vld, e_idx;
    @(posedge clk);
    r = rst; cur_tg = int'(xfer_len); cur_lp = int'(line_pix);
    #1;
    if (r) n = 0;
    else begin
      n++;
      if (n == 2) new_line();
      else if (n > 2) begin
        lt++;
        if (lt == m_lp * PIX) new_line();   // R10 period uses settings of the edge before
      end
    end
    prev_tg = cur_tg; prev_lp = cur_lp;
    if (n < 2) begin
      // R1 idle outputs
      chk("R1 xfer", int'(xfer_gate), 0);
      chk("R1 sh1", int'(sh1), 1);
      chk("R1 sh2", int'(sh2), 0);
      chk("R1 shlast", int'(sh_last), 1);
      chk("R1 rgate", int'(rst_gate), 0);
      chk("R1 clamp", int'(clamp), 0);
      chk("R1 lstart", int'(line_start), 0);
      chk("R1 vld", int'(elem_vld), 0);
      chk("R1 idx", int'(elem_idx), 0);
    end else begin
      p  = lt % PIX;
      pi = lt / PIX;
      e_tg  = (lt >= G && lt < G + m_t) ? 1 : 0;
      e_sh  = (pi < m_r0 || p < PIX / 2) ? 1 : 0;
      e_rg  = (p >= RBP && p < RBP + RBL) ? 1 : 0;
      e_cl  = (p >= RBP + RBL - CLO && p < RBP + RBL - CLO + CLL) ? 1 : 0;
      e_ls  = (lt == 0) ? 1 : 0;
      e_vld = (pi >= m_r0 && pi - m_r0 < NE) ? 1 : 0;
      e_idx = e_vld ? pi - m_r0 : 0;
      chk("R3 xfer gate", int'(xfer_gate), e_tg);
      chk((pi < m_r0) ? "R4 sh1 hold" : "R6 sh1 run", int'(sh1), e_sh);
      chk("R5 sh2", int'(sh2), 1 - e_sh);
      chk("R5 shlast", int'(sh_last), e_sh);
      chk("R7 rgate", int'(rst_gate), e_rg);
      chk("R8 clamp", int'(clamp), e_cl);
      chk("R2 R10 lstart", int'(line_start), e_ls);
      chk("R9 vld", int'(elem_vld), e_vld);
      chk("R9 idx", int'(elem_idx), e_idx);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();                 // R1 during reset
    rst = 1'b0;
    repeat (250) step();               // R3 width below range -> TG_MIN, R10 period below min
    xfer_len = 4'd15; line_pix = 8'd20;
    repeat (300) step();               // R3 clamp to TG_MAX, R10 longer period
    xfer_len = 4'd3; line_pix = 8'd14;
    repeat (200) step();
    xfer_len = 4'd9; line_pix = 8'd15; // R10 mid-line change applies next line
    repeat (300) step();
    rst = 1'b1;
    repeat (3) step();                 // R1 reset in mid-line
    rst = 1'b0;
    repeat (300) step();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule